// File: doc/BRIEF.md
# Temporal-Redundancy 2-of-5 Symbol Decoder

This block sits at the receiving end of a link that carries one-hot symbols as 2-of-(N+1) codewords. The sender merges each symbol with the one before it by a bitwise OR over the N low rails. It raises the extra top rail when the two symbols are equal, so every symbol effectively travels twice. The decoder keeps the last symbol it delivered and treats it as the expected contribution to the next codeword. It subtracts that history to recover the new symbol, and it uses the history to judge whether the received rail pattern can be trusted.

Codewords arrive under a four-phase return-to-zero handshake: a data word, then an acknowledge, then the all-zero spacer, then the acknowledge is released. Each data word gives exactly one result strobe. That strobe is either a good symbol, a repaired symbol (one rail lost in transit), or an error (a pattern that cannot be reconciled with the history). On an error, the history is kept unchanged so that the next clean codeword can still be decoded.

Top module: `redund_sym_decoder`

## Requirements
- R1: After reset `in_ack`, `dec_valid`, `err_flag` and `corr_flag` are low, `dec_data` is 0001 (bit 0 set), and that value is the history used for the first codeword.
- R2: With `in_ack` low, a non-zero `in_word` sampled at a clock edge sets `in_ack` at that edge. With `in_ack` high, an all-zero `in_word` clears it at the following edge. Every rise of `in_ack` comes with exactly one result strobe.
- R3: A two-rail word with top rail `in_word[4]` set and low rails equal to the history decodes to the history symbol, with `corr_flag` low.
- R4: A two-rail word with the top rail clear, whose low rails include the history bit, decodes to the other low rail, with `corr_flag` low.
- R5: A two-rail word that does not carry the history bit in its low rails (top rail set with a different low rail, or two low rails neither equal to the history) raises `err_flag`.
- R6: A word with exactly one low rail high, and that rail not the history bit, decodes to that rail with `corr_flag` high.
- R7: A word whose only high rail is the history bit, or only the top rail, decodes to the history symbol with `corr_flag` high.
- R8: A word with three or more rails high raises `err_flag`.
- R9: The strobes `dec_valid` and `err_flag` last one cycle and are never high together. `corr_flag` is high only with `dec_valid`.
- R10: `dec_data` is always one-hot. It changes only with `dec_valid`, and an error leaves it at the last delivered symbol, which remains the history for the next codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | SYM_W+1 | Received rails; bit SYM_W is the repeat rail, all-zero is the spacer |
| in_ack | output | 1 | Handshake acknowledge |
| dec_data | output | SYM_W | Last delivered one-hot symbol (also the history) |
| dec_valid | output | 1 | One-cycle strobe: a symbol was delivered |
| err_flag | output | 1 | One-cycle strobe: codeword rejected |
| corr_flag | output | 1 | With `dec_valid`: symbol was repaired |

## Verification
The only internal state is the history symbol, and it is also `dec_data`, so a wrong history is visible at once as a wrong symbol. It also changes how the very next codeword is judged. A history that moved on an error shows up on the clean codeword that follows: that codeword then decodes to the wrong symbol or is rejected. The bench therefore follows every injected fault with clean traffic, and it compares the data on error strobes as well as on good ones.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_FIX = 2'd1,
    RES_BAD = 2'd2
  } res_e;
endpackage

// File: rtl/rsd_rtz_sink.sv
module rsd_rtz_sink #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  output logic         ack_o,
  output logic         take_o
);
  logic ack_q;
  logic busy;

  assign busy   = |word_i;
  assign take_o = !ack_q && busy;
  assign ack_o  = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
    end else if (!ack_q && busy) begin
      ack_q <= 1'b1;
    end else if (ack_q && !busy) begin
      ack_q <= 1'b0;
    end
  end

  AST_TAKE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ack_o);  // R2
endmodule

// File: rtl/rsd_classify.sv
module rsd_classify
  import rsd_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic [SYM_W:0]   word_i,
  input  logic [SYM_W-1:0] hist_i,
  output res_e             res_o,
  output logic [SYM_W-1:0] sym_o
);
  localparam int W  = SYM_W + 1;
  localparam int CW = $clog2(W + 1);

  logic [SYM_W-1:0] lo;
  logic             rep;
  logic [CW-1:0]    cnt;
  logic             hit;

  assign lo  = word_i[SYM_W-1:0];
  assign rep = word_i[SYM_W];
  assign hit = |(lo & hist_i);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(word_i[i]);
    end
  end

  always_comb begin
    res_o = RES_BAD;
    sym_o = hist_i;
    if (cnt == CW'(2)) begin
      if (rep) begin
        if (lo == hist_i) begin
          res_o = RES_OK;
          sym_o = hist_i;
        end
      end else if (hit) begin
        res_o = RES_OK;
        sym_o = lo & ~hist_i;
      end
    end else if (cnt == CW'(1)) begin
      res_o = RES_FIX;
      if (rep || hit) begin
        sym_o = hist_i;
      end else begin
        sym_o = lo;
      end
    end
  end
endmodule

// File: rtl/rsd_history.sv
module rsd_history
  import rsd_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  res_e             res_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] hist_o,
  output logic             vld_o,
  output logic             err_o,
  output logic             cor_o
);
  localparam logic [SYM_W-1:0] HIST_INIT = SYM_W'(1);

  logic [SYM_W-1:0] hist_q;
  logic             vld_q, err_q, cor_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= HIST_INIT;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      cor_q  <= 1'b0;
    end else begin
      vld_q <= take_i && (res_i != RES_BAD);
      err_q <= take_i && (res_i == RES_BAD);
      cor_q <= take_i && (res_i == RES_FIX);
      if (take_i && (res_i != RES_BAD)) begin
        hist_q <= sym_i;
      end
    end
  end

  assign hist_o = hist_q;
  assign vld_o  = vld_q;
  assign err_o  = err_q;
  assign cor_o  = cor_q;

  AST_DATA_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(hist_o) == 1);  // R10
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(hist_o));  // R10
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> $stable(hist_o));  // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vld_o, err_o}));  // R9
  AST_CORR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    cor_o |-> vld_o);  // R9
endmodule

// File: rtl/redund_sym_decoder.sv
module redund_sym_decoder
  import rsd_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W:0]   in_word,
  output logic             in_ack,
  output logic [SYM_W-1:0] dec_data,
  output logic             dec_valid,
  output logic             err_flag,
  output logic             corr_flag
);
  localparam int W = SYM_W + 1;

  logic             take;
  res_e             res;
  logic [SYM_W-1:0] sym;
  logic [SYM_W-1:0] hist;

  rsd_rtz_sink #(.W(W)) u_sink (
    .clk    (clk),
    .rst    (rst),
    .word_i (in_word),
    .ack_o  (in_ack),
    .take_o (take)
  );

  rsd_classify #(.SYM_W(SYM_W)) u_cls (
    .word_i (in_word),
    .hist_i (hist),
    .res_o  (res),
    .sym_o  (sym)
  );

  rsd_history #(.SYM_W(SYM_W)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .take_i (take),
    .res_i  (res),
    .sym_i  (sym),
    .hist_o (hist),
    .vld_o  (dec_valid),
    .err_o  (err_flag),
    .cor_o  (corr_flag)
  );

  assign dec_data = hist;

  AST_STROBE_ON_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
    (dec_valid || err_flag) |-> $rose(in_ack));  // R2
  AST_ACK_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> (dec_valid || err_flag));  // R2
endmodule

// File: tb/redund_sym_decoder_tb.sv
module redund_sym_decoder_tb_top;
  localparam int SYM_W = 4;

  typedef struct packed {
    logic             err;
    logic             corr;
    logic [SYM_W-1:0] data;
    logic [3:0]       req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SYM_W:0]   in_word = '0;
  logic             in_ack;
  logic [SYM_W-1:0] dec_data;
  logic             dec_valid, err_flag, corr_flag;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t sb[$];
  logic [SYM_W-1:0] prev = 4'b0001;

  always #5 clk = ~clk;

  redund_sym_decoder #(.SYM_W(SYM_W)) dut_i (
    .clk(clk), .rst(rst), .in_word(in_word), .in_ack(in_ack),
    .dec_data(dec_data), .dec_valid(dec_valid),
    .err_flag(err_flag), .corr_flag(corr_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each result strobe with the scoreboard head
  always @(negedge clk) begin
    if (!rst && (dec_valid || err_flag)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", {dec_valid, err_flag}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(err_flag == e.err && dec_valid == !e.err && corr_flag == e.corr
            && dec_data == e.data, $sformatf("R%0d", e.req),
            {err_flag, corr_flag, dec_data}, {e.err, e.corr, e.data});
      end
    end
  end

  // driver: one full four-phase transfer
  task automatic send(input logic [SYM_W:0] w, input logic e_err,
                      input logic e_corr, input logic [SYM_W-1:0] e_data,
                      input logic [3:0] req);
    exp_t e;
    e.err = e_err; e.corr = e_corr; e.data = e_data; e.req = req;
    sb.push_back(e);
    in_word = w;
    @(negedge clk);
    chk(in_ack == 1'b1, "R2", in_ack, 1);
    in_word = '0;
    @(negedge clk);
    chk(in_ack == 1'b0, "R2", in_ack, 0);
    chk(!dec_valid && !err_flag, "R9", {dec_valid, err_flag}, 0);
    @(negedge clk);
    if (!e_err) prev = e_data;
  endtask

  task automatic clean(input logic [SYM_W-1:0] cur, input logic [3:0] req);
    logic [SYM_W:0] w;
    w = (cur == prev) ? {1'b1, cur} : {1'b0, cur | prev};
    send(w, 1'b0, 1'b0, cur, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ack == 0 && dec_valid == 0 && err_flag == 0 && corr_flag == 0,
        "R1", {in_ack, dec_valid, err_flag, corr_flag}, 0);
    chk(dec_data == 4'b0001, "R1", dec_data, 1);
    // R1/R3: first word repeats the reset history
    send(5'b10001, 0, 0, 4'b0001, 4'd1);
    clean(4'b0010, 4'd4);   // R4
    clean(4'b0010, 4'd3);   // R3
    clean(4'b0100, 4'd4);
    clean(4'b1000, 4'd4);
    clean(4'b1000, 4'd3);
    clean(4'b0001, 4'd4);
    // R6: lone low rail not the history bit
    send(5'b00100, 0, 1, 4'b0100, 4'd6);
    // R7: lone rail equal to history, then lone top rail
    send(5'b00100, 0, 1, 4'b0100, 4'd7);
    send(5'b10000, 0, 1, 4'b0100, 4'd7);
    // R5: legal 2-of-5 words missing the history bit
    send(5'b10010, 1, 0, 4'b0100, 4'd5);
    send(5'b00011, 1, 0, 4'b0100, 4'd5);
    // R8: three or more rails
    send(5'b01101, 1, 0, 4'b0100, 4'd8);
    send(5'b11111, 1, 0, 4'b0100, 4'd8);
    // R10: history held through errors, clean decode resumes
    clean(4'b1000, 4'd10);
    clean(4'b0001, 4'd10);
    // R2: data held across several cycles keeps ack high, one strobe only
    sb.push_back('{err: 1'b0, corr: 1'b0, data: 4'b0010, req: 4'd2});
    in_word = 5'b00011;
    repeat (4) @(negedge clk);
    chk(in_ack == 1'b1, "R2", in_ack, 1);
    in_word = '0;
    @(negedge clk);
    chk(in_ack == 1'b0, "R2", in_ack, 0);
    @(negedge clk);
    chk(sb.size() == 0, "R9", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule